// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Mode Controller

This block tracks the power mode of a processor domain (Run, Sleep, Stop, Standby) and decides, every cycle, whether the core clock enable and the free-running clock enable are on. It also decides which source feeds them: the configured system clock or the internal RC clock. A small configuration register holds one debug override per low-power mode. With an override set, a debugger keeps clocks alive in that mode instead of losing the core. The override changes how the mode gates the clocks, re-sources them or resets the domain.

The same register holds one freeze bit per watchdog. When the core is halted by a debugger, a set freeze bit stops that watchdog's counter clock enable. The register also holds a trace enable and a two-bit trace mode, which are decoded into an asynchronous/synchronous indication and a lane count. Leaving Standby requests a reset. A sticky status flag records that the domain resumed from an unpowered Standby, and software clears it by writing 1. All controls are plain level or pulse pins sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready interface.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset, the configuration register reads 0, `lp_state` is Run (0), both clock enables are 1, `src_rc` is 1 (internal RC), and `rst_req` and `resume_flag` are 0.
- R2: A configuration write stores bits 0,1,2 (Sleep, Stop and Standby debug), 5 (trace enable), 7:6 (trace mode), 8 (independent watchdog freeze) and 9 (window watchdog freeze). Bits 4:3 always read 0. Without a write, the register holds its value.
- R3: In Sleep (`lp_state`=1), `fclk_en` is 1 and `hclk_en` equals the Sleep debug bit. `src_rc` keeps its value from before entry, and it still holds that value after wakeup.
- R4: In Stop (`lp_state`=2), both clock enables equal the Stop debug bit and `src_rc` is 1.
- R5: On exit from Stop, the source select returns to internal RC (`src_rc`=1), whatever the Stop debug bit.
- R6: In Standby (`lp_state`=3) with the Standby debug bit at 0, both clock enables are 0. A wakeup raises `rst_req` for exactly the first cycle in Run and sets `resume_flag`.
- R7: In Standby with the Standby debug bit at 1, both clock enables are 1, `src_rc` is 1 and `rst_req` is held at 1. After wakeup, `src_rc` is 1 and `resume_flag` stays 0.
- R8: Entry requests are acted on only in Run, with Standby taking priority over Stop and Stop over Sleep. In any low-power state, `wake` returns the controller to Run on the next edge. `wake` in Run has no effect.
- R9: `wdg_run[i]` is 0 exactly when `core_halted` is 1 and freeze bit 8+i is 1. Index 0 is the independent watchdog and index 1 is the window watchdog.
- R10: With trace enable (bit 5) at 0, `trace_async` and `trace_lanes` are 0 whatever the mode. With trace enable at 1, mode 00 gives `trace_async`=1 and 0 lanes, and modes 01, 10 and 11 give 1, 2 and 4 lanes.
- R11: `resume_flag` stays set until `resume_clr` is pulsed. When a setting Standby exit and a clear fall in the same cycle, the set wins.
- R12: `src_wr` loads the source select (`src_sys`=1 selects the system clock, so `src_rc`=0) only in Run. In the other states it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter Sleep |
| stop_req | input | 1 | Request to enter Stop |
| stby_req | input | 1 | Request to enter Standby |
| wake | input | 1 | Wakeup event |
| core_halted | input | 1 | Core halted by debugger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration write data |
| cfg_rdata | output | 10 | Configuration register contents |
| src_wr | input | 1 | Source select write strobe |
| src_sys | input | 1 | Source select value, 1 = system clock |
| resume_clr | input | 1 | Write-1 clear of the resume flag |
| lp_state | output | 2 | Mode: 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| hclk_en | output | 1 | Core clock enable |
| fclk_en | output | 1 | Free-running clock enable |
| src_rc | output | 1 | 1 = clocks from internal RC, 0 = system clock |
| rst_req | output | 1 | System reset request |
| resume_flag | output | 1 | Resumed from unpowered Standby |
| wdg_run | output | 2 | Watchdog counter clock enables |
| trace_async | output | 1 | Trace in asynchronous mode |
| trace_lanes | output | 3 | Synchronous trace data width |

## Verification
Two things can meet in one cycle. A wakeup out of unpowered Standby sets the resume flag, and software may clear that flag on the same edge. The bench parks the controller in Standby with the debug bit at 0, raises `wake` and `resume_clr` together, and expects the flag to read 1 afterwards. A later lone clear must then bring it to 0. A second collision is a source-select write arriving while a low-power state is held. The bench writes the opposite source during each low-power state and expects `src_rc` to keep the value predicted for that state.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    LP_RUN   = 2'd0,
    LP_SLEEP = 2'd1,
    LP_STOP  = 2'd2,
    LP_STBY  = 2'd3
  } lp_state_e;

  // configuration bit positions
  localparam int B_DSLEEP = 0;
  localparam int B_DSTOP  = 1;
  localparam int B_DSTBY  = 2;
  localparam int B_RSV_LO = 3;
  localparam int B_RSV_HI = 4;
  localparam int B_TRC_EN = 5;
  localparam int B_TRC_M  = 6;
  localparam int B_WDG0   = 8;

  function automatic logic [2:0] lanes_of(input logic en, input logic [1:0] mode);
    logic [2:0] one;
    one = 3'd1;
    if (!en || mode == 2'd0) return 3'd0;
    return one << (mode - 2'd1);
  endfunction

endpackage

// File: rtl/lpc_cfg_reg.sv
module lpc_cfg_reg #(
  parameter int W = 10,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & ~RSVD;
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      stop_req,
  input  logic      stby_req,
  input  logic      wake,
  input  logic      src_wr,
  input  logic      src_sys,
  output lp_state_e state,
  output logic      src_rc_q
);

  lp_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      LP_RUN: begin
        if (stby_req)       nxt = LP_STBY;
        else if (stop_req)  nxt = LP_STOP;
        else if (sleep_req) nxt = LP_SLEEP;
      end
      default: if (wake) nxt = LP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LP_RUN;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      src_rc_q <= 1'b1;
    else if ((state == LP_STOP || state == LP_STBY) && wake)
      src_rc_q <= 1'b1;
    else if (state == LP_RUN && src_wr)
      src_rc_q <= !src_sys;
  end

  assert_wake_to_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_RUN && wake) |=> state == LP_RUN);
  assert_lp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_RUN && !wake) |=> $stable(state));
  assert_stop_exit_rc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_STOP && wake) |=> src_rc_q);
  assert_src_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_RUN && !wake) |=> $stable(src_rc_q));

endmodule

// File: rtl/lpc_resume_stat.sv
module lpc_resume_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic in_stby,
  input  logic wake,
  input  logic dbg_stby,
  input  logic clr,
  output logic flag,
  output logic exit_pulse
);

  logic cold_exit;
  assign cold_exit = in_stby && wake && !dbg_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag       <= 1'b0;
      exit_pulse <= 1'b0;
    end else begin
      exit_pulse <= cold_exit;
      if (cold_exit) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cold_exit |=> flag);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

endmodule

// File: rtl/lpc_wdg_gate.sv
module lpc_wdg_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] frz,
  input  logic         halted,
  output logic [N-1:0] run
);

  for (genvar i = 0; i < N; i++) begin : g_wdg
    assign run[i] = !(frz[i] && halted);
  end

  assert_wdg_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (&run));

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpc_pkg::*;
#(
  parameter int  NUM_WDG = 2,
  localparam int CFG_W   = B_WDG0 + NUM_WDG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               stop_req,
  input  logic               stby_req,
  input  logic               wake,
  input  logic               core_halted,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               src_wr,
  input  logic               src_sys,
  input  logic               resume_clr,
  output logic [1:0]         lp_state,
  output logic               hclk_en,
  output logic               fclk_en,
  output logic               src_rc,
  output logic               rst_req,
  output logic               resume_flag,
  output logic [NUM_WDG-1:0] wdg_run,
  output logic               trace_async,
  output logic [2:0]         trace_lanes
);

  localparam logic [CFG_W-1:0] RSVD_MASK =
    (CFG_W'(1) << B_RSV_LO) | (CFG_W'(1) << B_RSV_HI);

  logic [CFG_W-1:0] cfg_q;
  lp_state_e        state;
  logic             src_rc_q;
  logic             exit_pulse;

  lpc_cfg_reg #(.W(CFG_W), .RSVD(RSVD_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  lpc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
    .stby_req(stby_req), .wake(wake), .src_wr(src_wr), .src_sys(src_sys),
    .state(state), .src_rc_q(src_rc_q)
  );

  lpc_resume_stat u_stat (
    .clk(clk), .rst_n(rst_n), .in_stby(state == LP_STBY), .wake(wake),
    .dbg_stby(cfg_q[B_DSTBY]), .clr(resume_clr), .flag(resume_flag),
    .exit_pulse(exit_pulse)
  );

  lpc_wdg_gate #(.N(NUM_WDG)) u_wdg (
    .clk(clk), .rst_n(rst_n), .frz(cfg_q[B_WDG0 +: NUM_WDG]),
    .halted(core_halted), .run(wdg_run)
  );

  always_comb begin
    hclk_en = 1'b1;
    fclk_en = 1'b1;
    src_rc  = src_rc_q;
    case (state)
      LP_SLEEP: hclk_en = cfg_q[B_DSLEEP];
      LP_STOP: begin
        hclk_en = cfg_q[B_DSTOP];
        fclk_en = cfg_q[B_DSTOP];
        src_rc  = 1'b1;
      end
      LP_STBY: begin
        hclk_en = cfg_q[B_DSTBY];
        fclk_en = cfg_q[B_DSTBY];
        src_rc  = 1'b1;
      end
      default: ;
    endcase
  end

  assign rst_req     = (state == LP_STBY && cfg_q[B_DSTBY]) || exit_pulse;
  assign lp_state    = state;
  assign cfg_rdata   = cfg_q;
  assign trace_async = cfg_q[B_TRC_EN] && (cfg_q[B_TRC_M +: 2] == 2'd0);
  assign trace_lanes = lanes_of(cfg_q[B_TRC_EN], cfg_q[B_TRC_M +: 2]);

  assert_sleep_fclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_SLEEP) |-> fclk_en);
  assert_stop_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_STOP && !cfg_q[B_DSTOP]) |-> (!hclk_en && !fclk_en));
  assert_stby_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_STBY && cfg_q[B_DSTBY]) |-> rst_req);
  assert_rsvd_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[B_RSV_HI:B_RSV_LO] == 2'b00);

endmodule

// File: tb/lpclk_ctrl_tb_top.sv
module lpclk_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, stop_req = 0, stby_req = 0, wake = 0, core_halted = 0;
  logic cfg_we = 0, src_wr = 0, src_sys = 0, resume_clr = 0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic [1:0] lp_state;
  logic hclk_en, fclk_en, src_rc, rst_req, resume_flag, trace_async;
  logic [1:0] wdg_run;
  logic [2:0] trace_lanes;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpclk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
    .stby_req(stby_req), .wake(wake), .core_halted(core_halted),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_wr(src_wr), .src_sys(src_sys), .resume_clr(resume_clr),
    .lp_state(lp_state), .hclk_en(hclk_en), .fclk_en(fclk_en),
    .src_rc(src_rc), .rst_req(rst_req), .resume_flag(resume_flag),
    .wdg_run(wdg_run), .trace_async(trace_async), .trace_lanes(trace_lanes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    sleep_req = 0; stop_req = 0; stby_req = 0; wake = 0;
    cfg_we = 0; src_wr = 0; resume_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cfg", 32'(cfg_rdata), 0);
    chk("R1 state", 32'(lp_state), 0);
    chk("R1 hclk", 32'(hclk_en), 1);
    chk("R1 fclk", 32'(fclk_en), 1);
    chk("R1 src", 32'(src_rc), 1);
    chk("R1 rst", 32'(rst_req), 0);
    chk("R1 flag", 32'(resume_flag), 0);
    rst_n = 1'b1;
    tick();

    // R2 reserved bits
    cfg_we = 1; cfg_wdata = 10'h3FF; tick(); idle_inputs();
    chk("R2 rsvd", 32'(cfg_rdata), 32'h3E7);
    tick();
    chk("R2 hold", 32'(cfg_rdata), 32'h3E7);

    // R10 trace sweep
    for (int v = 0; v < 8; v++) begin
      logic en;
      logic [1:0] md;
      logic [2:0] exp_l;
      cfg_we = 1; cfg_wdata = 10'(v << 5); tick(); idle_inputs();
      en = v[0]; md = 2'(v >> 1);
      exp_l = (en && md != 0) ? 3'(1 << (md - 1)) : 3'd0;
      chk("R10 lanes", 32'(trace_lanes), 32'(exp_l));
      chk("R10 async", 32'(trace_async), 32'(en && md == 0));
    end

    // R9 watchdog sweep
    for (int f = 0; f < 4; f++) begin
      for (int h = 0; h < 2; h++) begin
        cfg_we = 1; cfg_wdata = 10'(f << 8); tick(); idle_inputs();
        core_halted = h[0]; #1;
        chk("R9 wdg_run", 32'(wdg_run), 32'(~(2'(f) & {2{h[0]}}) & 2'b11));
      end
    end
    core_halted = 0;

    // R8 wake in Run has no effect
    wake = 1; tick(); idle_inputs();
    chk("R8 run wake", 32'(lp_state), 0);
    chk("R8 run wake flag", 32'(resume_flag), 0);

    // R8 priority
    sleep_req = 1; stop_req = 1; stby_req = 1; tick(); idle_inputs();
    chk("R8 prio stby", 32'(lp_state), 3);
    sleep_req = 1; tick(); idle_inputs();
    chk("R8 req ignored in lp", 32'(lp_state), 3);
    wake = 1; tick(); idle_inputs(); tick();
    resume_clr = 1; tick(); idle_inputs();
    sleep_req = 1; stop_req = 1; tick(); idle_inputs();
    chk("R8 prio stop", 32'(lp_state), 2);
    wake = 1; tick(); idle_inputs();
    chk("R8 wake stop", 32'(lp_state), 0);

    // main sweep: debug bits x mode x source
    for (int d = 0; d < 8; d++) begin
      for (int m = 1; m < 4; m++) begin
        for (int s = 0; s < 2; s++) begin
          logic [2:0] db;
          logic exp_h, exp_f, exp_s, exp_r, exp_flag;
          db = 3'(d);
          cfg_we = 1; cfg_wdata = 10'(d); src_wr = 1; src_sys = s[0];
          tick(); idle_inputs();
          chk("R12 src in run", 32'(src_rc), 32'(!s[0]));
          chk("R2 cfg", 32'(cfg_rdata), 32'(d));
          case (m)
            1: sleep_req = 1;
            2: stop_req = 1;
            default: stby_req = 1;
          endcase
          tick(); idle_inputs();
          case (m)
            1: begin exp_f = 1; exp_h = db[0]; exp_s = !s[0]; exp_r = 0; end
            2: begin exp_f = db[1]; exp_h = db[1]; exp_s = 1; exp_r = 0; end
            default: begin exp_f = db[2]; exp_h = db[2]; exp_s = 1; exp_r = db[2]; end
          endcase
          chk("R8 enter", 32'(lp_state), 32'(m));
          chk(m == 1 ? "R3 hclk" : (m == 2 ? "R4 hclk" : "R6/R7 hclk"), 32'(hclk_en), 32'(exp_h));
          chk(m == 1 ? "R3 fclk" : (m == 2 ? "R4 fclk" : "R6/R7 fclk"), 32'(fclk_en), 32'(exp_f));
          chk(m == 1 ? "R3 src" : (m == 2 ? "R4 src" : "R7 src"), 32'(src_rc), 32'(exp_s));
          chk("R7 rst in lp", 32'(rst_req), 32'(exp_r));
          src_wr = 1; src_sys = !s[0]; tick(); idle_inputs();
          chk("R12 src write ignored", 32'(src_rc), 32'(exp_s));
          chk("R8 lp hold", 32'(lp_state), 32'(m));
          wake = 1; tick(); idle_inputs();
          exp_flag = (m == 3) && !db[2];
          chk("R8 wake", 32'(lp_state), 0);
          chk(m == 1 ? "R3 src kept" : "R5/R7 src rc", 32'(src_rc), 32'(m == 1 ? !s[0] : 1'b1));
          chk("R6 flag", 32'(resume_flag), 32'(exp_flag));
          chk("R6 rst pulse", 32'(rst_req), 32'(exp_flag));
          tick();
          chk("R6 rst drop", 32'(rst_req), 0);
          chk("R11 flag hold", 32'(resume_flag), 32'(exp_flag));
          resume_clr = 1; tick(); idle_inputs();
          chk("R11 clear", 32'(resume_flag), 0);
        end
      end
    end

    // R11 set and clear in the same cycle
    cfg_we = 1; cfg_wdata = 10'h000; tick(); idle_inputs();
    stby_req = 1; tick(); idle_inputs();
    wake = 1; resume_clr = 1; tick(); idle_inputs();
    chk("R11 set wins", 32'(resume_flag), 1);
    resume_clr = 1; tick(); idle_inputs();
    chk("R11 lone clear", 32'(resume_flag), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule